// File: doc/BRIEF.md
# Commit-Time Deferred Control-Register Write Buffer

This block sits beside one in-flight instruction of an out-of-order core. Whenever the instruction produces a control-register write during execution, the pair (register index, value) is captured in a small buffer. The architectural control-register file is not touched at that point. If the instruction is squashed, the captured pairs are thrown away and nothing is written. If it retires, the pairs are replayed toward the register file's side-effecting write port one per cycle, oldest first.

A done strobe marks the cycle in which the last replayed write is presented. Commit logic holds the program counter until that strobe, so every deferred write lands before the core moves past the retiring instruction. The buffer holds as many entries as an instruction has destination registers. A write aimed at the full status register raises a serialize indication, which tells the pipeline to keep younger instructions from issuing until the drain completes.

A setup strobe empties the buffer when a new instruction is assigned to it. An append that finds the buffer full is dropped and flagged.

Top module: `crdefer_buffer`

## Requirements
- R1: While collecting, each cycle with `cr_wr_valid_i` high and fewer than DEPTH entries held records the index and value and raises `count_o` by one in the following cycle. `rf_wr_en_o` stays low while collecting.
- R2: `setup_i` while collecting empties the buffer (`count_o` reads 0 the next cycle) and clears `serialize_o`. No write is issued.
- R3: `commit_i` while collecting, with at least one entry held, starts a drain. Starting in the cycle after the commit edge, one write per cycle appears on `rf_wr_en_o`/`rf_wr_idx_o`/`rf_wr_data_o`, in recording order.
- R4: `drain_done_o` is high in the cycle that presents the last write. A commit with no entries issues no write and raises `drain_done_o` for one cycle, in the cycle after the commit edge.
- R5: `squash_i` while collecting empties the buffer without any write. Squash or setup wins over a commit in the same cycle.
- R6: Capacity is DEPTH (default 4). An append when DEPTH entries are held is dropped: `count_o` is unchanged, `overflow_o` is high for one cycle after that edge, and no extra write occurs at commit.
- R7: An append accepted in the same cycle as the commit is part of the drain and is written last.
- R8: During a drain, `cr_wr_valid_i`, `commit_i`, `squash_i` and `setup_i` have no effect. The drain completes unchanged and no entry remains afterwards.
- R9: An accepted append whose index equals STATUS_IDX (default 2) sets `serialize_o` from the next cycle on. It is cleared after the drain's last write, or by squash or setup.
- R10: In the cycle after `drain_done_o`, `count_o` reads 0 and `rf_wr_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_i | input | 1 | New instruction assigned; empties the buffer |
| squash_i | input | 1 | Instruction squashed; discard entries |
| commit_i | input | 1 | Instruction retires; start draining |
| cr_wr_valid_i | input | 1 | Execute-side control-register write strobe |
| cr_wr_idx_i | input | IDX_W | Index of the captured write |
| cr_wr_data_i | input | DATA_W | Value of the captured write |
| rf_wr_en_o | output | 1 | Write strobe toward the register file |
| rf_wr_idx_o | output | IDX_W | Index of the replayed write |
| rf_wr_data_o | output | DATA_W | Value of the replayed write |
| drain_done_o | output | 1 | All deferred writes presented; PC may advance |
| overflow_o | output | 1 | One-cycle flag: an append was dropped |
| serialize_o | output | 1 | Pending status-register write; hold younger issue |
| count_o | output | $clog2(DEPTH+1) | Entries currently held |

## Verification
Every registered result shows one cycle after the edge that samples its cause:
- `count_o`, `overflow_o` and `serialize_o` change in the cycle after an append, clear or drain end.
- The first replayed write appears in the cycle after the commit edge, and entry i appears i cycles later.
- The done strobe is concurrent with the last write, or one cycle after an empty commit.

The bench drives inputs just after the falling edge and advances a queue-based model on the rising edge. It compares every output against that model at the next falling edge, so each expectation is checked in exactly the cycle it is due. Scenario-level checks after each sequence confirm the emptied state, the ignored inputs during a drain, and the dropped overflow entry at the ports.

// File: rtl/crdefer_pkg.sv
package crdefer_pkg;

  typedef enum logic {
    ST_COLLECT = 1'b0,
    ST_DRAIN   = 1'b1
  } drain_state_e;

  // True when another entry fits.
  function automatic logic has_room(input int unsigned held, input int unsigned depth);
    return held < depth;
  endfunction

  // True when slot is the final held entry.
  function automatic logic is_final_slot(input int unsigned slot, input int unsigned held);
    return (slot + 1) == held;
  endfunction

endpackage

// File: rtl/crdefer_store.sv
module crdefer_store #(
  parameter int DEPTH  = 4,
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_slot,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_slot,
  output logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [IDX_W-1:0]  idx_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        idx_mem[s]  <= '0;
        data_mem[s] <= '0;
      end else if (wr_en && (32'(wr_slot) == s)) begin
        idx_mem[s]  <= wr_idx;
        data_mem[s] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_idx  = '0;
    rd_data = '0;
    for (int s = 0; s < DEPTH; s++) begin
      if (32'(rd_slot) == s) begin
        rd_idx  = idx_mem[s];
        rd_data = data_mem[s];
      end
    end
  end

endmodule

// File: rtl/crdefer_fill.sv
module crdefer_fill
  import crdefer_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             collecting,
  input  logic             clear_req,
  input  logic             append_valid,
  input  logic             drain_finish,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_after,
  output logic [PTR_W-1:0] append_slot,
  output logic             append_accept,
  output logic             append_drop
);

  logic room;
  logic live_append;

  assign room          = has_room(32'(count_q), DEPTH);
  assign live_append   = collecting && append_valid && !clear_req;
  assign append_accept = live_append && room;
  assign append_drop   = live_append && !room;
  assign append_slot   = count_q[PTR_W-1:0];
  assign count_after   = count_q + CNT_W'(append_accept);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= '0;
    else if (collecting && clear_req)
      count_q <= '0;
    else if (drain_finish)
      count_q <= '0;
    else if (append_accept)
      count_q <= count_after;
  end

endmodule

// File: rtl/crdefer_drain.sv
module crdefer_drain
  import crdefer_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_req,
  input  logic [CNT_W-1:0] pending_after,
  input  logic [CNT_W-1:0] held,
  output logic             collecting,
  output logic             draining,
  output logic             drain_last,
  output logic             done,
  output logic [PTR_W-1:0] rd_slot
);

  drain_state_e     state_q;
  logic [PTR_W-1:0] ptr_q;
  logic             empty_ack_q;

  assign collecting = (state_q == ST_COLLECT);
  assign draining   = (state_q == ST_DRAIN);
  assign drain_last = draining && is_final_slot(32'(ptr_q), 32'(held));
  assign done       = drain_last || empty_ack_q;
  assign rd_slot    = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_COLLECT;
      ptr_q       <= '0;
      empty_ack_q <= 1'b0;
    end else begin
      empty_ack_q <= 1'b0;
      unique case (state_q)
        ST_COLLECT: begin
          if (commit_req) begin
            if (pending_after != '0) begin
              state_q <= ST_DRAIN;
              ptr_q   <= '0;
            end else begin
              empty_ack_q <= 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (drain_last) begin
            state_q <= ST_COLLECT;
            ptr_q   <= '0;
          end else begin
            ptr_q <= ptr_q + PTR_W'(1);
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

endmodule

// File: rtl/crdefer_buffer.sv
module crdefer_buffer #(
  parameter int DEPTH      = 4,
  parameter int IDX_W      = 6,
  parameter int DATA_W     = 32,
  parameter int STATUS_IDX = 2,
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_i,
  input  logic              squash_i,
  input  logic              commit_i,
  input  logic              cr_wr_valid_i,
  input  logic [IDX_W-1:0]  cr_wr_idx_i,
  input  logic [DATA_W-1:0] cr_wr_data_i,
  output logic              rf_wr_en_o,
  output logic [IDX_W-1:0]  rf_wr_idx_o,
  output logic [DATA_W-1:0] rf_wr_data_o,
  output logic              drain_done_o,
  output logic              overflow_o,
  output logic              serialize_o,
  output logic [CNT_W-1:0]  count_o
);

  // Named internal events, observed by the checker.
  logic             collecting;
  logic             draining;
  logic             drain_last;
  logic             clear_req;
  logic             commit_req;
  logic             append_accept;
  logic             append_drop;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_after;
  logic [PTR_W-1:0] append_slot;
  logic [PTR_W-1:0] rd_slot;
  logic             overflow_q;
  logic             serialize_q;

  assign clear_req  = setup_i || squash_i;
  assign commit_req = collecting && commit_i && !clear_req;

  crdefer_fill #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_fill (
    .clk           (clk),
    .rst_n         (rst_n),
    .collecting    (collecting),
    .clear_req     (clear_req),
    .append_valid  (cr_wr_valid_i),
    .drain_finish  (drain_last),
    .count_q       (count_q),
    .count_after   (count_after),
    .append_slot   (append_slot),
    .append_accept (append_accept),
    .append_drop   (append_drop)
  );

  crdefer_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (append_accept),
    .wr_slot (append_slot),
    .wr_idx  (cr_wr_idx_i),
    .wr_data (cr_wr_data_i),
    .rd_slot (rd_slot),
    .rd_idx  (rf_wr_idx_o),
    .rd_data (rf_wr_data_o)
  );

  crdefer_drain #(.CNT_W(CNT_W), .PTR_W(PTR_W)) u_drain (
    .clk           (clk),
    .rst_n         (rst_n),
    .commit_req    (commit_req),
    .pending_after (count_after),
    .held          (count_q),
    .collecting    (collecting),
    .draining      (draining),
    .drain_last    (drain_last),
    .done          (drain_done_o),
    .rd_slot       (rd_slot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow_q  <= 1'b0;
      serialize_q <= 1'b0;
    end else begin
      overflow_q <= append_drop;
      if (collecting && clear_req)
        serialize_q <= 1'b0;
      else if (drain_last)
        serialize_q <= 1'b0;
      else if (append_accept && (32'(cr_wr_idx_i) == STATUS_IDX))
        serialize_q <= 1'b1;
    end
  end

  assign rf_wr_en_o  = draining;
  assign overflow_o  = overflow_q;
  assign serialize_o = serialize_q;
  assign count_o     = count_q;

endmodule

// File: rtl/crdefer_buffer_chk.sv
module crdefer_buffer_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             setup_i,
  input logic             squash_i,
  input logic             commit_i,
  input logic             collecting,
  input logic             drain_last,
  input logic             append_drop,
  input logic             rf_wr_en_o,
  input logic             overflow_o,
  input logic             serialize_o,
  input logic [CNT_W-1:0] count_o
);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_o) <= DEPTH);

  assert_drop_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    append_drop |=> overflow_o);

  assert_squash_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && squash_i) |=> (!rf_wr_en_o && count_o == '0));

  assert_commit_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && commit_i && !squash_i && !setup_i && count_o != '0) |=> rf_wr_en_o);

  assert_drain_continuous_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_en_o && !drain_last) |=> rf_wr_en_o);

  assert_write_has_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en_o |-> (count_o != '0));

  assert_empty_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    drain_last |=> (!rf_wr_en_o && count_o == '0));

  assert_serialize_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_last |=> !serialize_o);

endmodule

bind crdefer_buffer crdefer_buffer_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .setup_i     (setup_i),
  .squash_i    (squash_i),
  .commit_i    (commit_i),
  .collecting  (collecting),
  .drain_last  (drain_last),
  .append_drop (append_drop),
  .rf_wr_en_o  (rf_wr_en_o),
  .overflow_o  (overflow_o),
  .serialize_o (serialize_o),
  .count_o     (count_o)
);

// File: tb/tb_crdefer_buffer.sv
`timescale 1ns/1ps
module tb_crdefer_buffer;

  localparam int DEPTH  = 4;
  localparam int IDX_W  = 6;
  localparam int DATA_W = 32;
  localparam int STAT   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic su = 0, sq = 0, cm = 0, wv = 0;
  logic [IDX_W-1:0]  wi = '0;
  logic [DATA_W-1:0] wd = '0;
  logic              wr_en, done, ovf, ser;
  logic [IDX_W-1:0]  wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [2:0]        cnt;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  crdefer_buffer dut (
    .clk(clk), .rst_n(rst_n), .setup_i(su), .squash_i(sq), .commit_i(cm),
    .cr_wr_valid_i(wv), .cr_wr_idx_i(wi), .cr_wr_data_i(wd),
    .rf_wr_en_o(wr_en), .rf_wr_idx_o(wr_idx), .rf_wr_data_o(wr_data),
    .drain_done_o(done), .overflow_o(ovf), .serialize_o(ser), .count_o(cnt)
  );

  // Behavioural reference model
  logic [IDX_W-1:0]  q_idx[$];
  logic [DATA_W-1:0] q_dat[$];
  bit m_drain, m_empty, m_ovf, m_ser;
  int m_ptr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_idx.delete(); q_dat.delete();
      m_drain = 0; m_empty = 0; m_ovf = 0; m_ser = 0; m_ptr = 0;
    end else if (m_drain) begin
      m_empty = 0; m_ovf = 0;
      if (m_ptr == q_idx.size() - 1) begin
        q_idx.delete(); q_dat.delete();
        m_drain = 0; m_ser = 0; m_ptr = 0;
      end else m_ptr++;
    end else begin
      m_empty = 0; m_ovf = 0;
      if (su || sq) begin
        q_idx.delete(); q_dat.delete(); m_ser = 0;
      end else begin
        if (wv) begin
          if (q_idx.size() < DEPTH) begin
            q_idx.push_back(wi); q_dat.push_back(wd);
            if (wi == STAT) m_ser = 1;
          end else m_ovf = 1;
        end
        if (cm) begin
          if (q_idx.size() > 0) begin m_drain = 1; m_ptr = 0; end
          else m_empty = 1;
        end
      end
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R3 wr_en", wr_en, m_drain);
      if (m_drain) begin
        check("R3 wr_idx order", wr_idx, q_idx[m_ptr]);
        check("R3 wr_data order", wr_data, q_dat[m_ptr]);
      end
      check("R4 done", done, m_empty || (m_drain && m_ptr == q_idx.size() - 1));
      check("R6 overflow", ovf, m_ovf);
      check("R9 serialize", ser, m_ser);
      check("R1 count", cnt, q_idx.size());
    end
  end

  task automatic drive(input logic v, input int i, input int d,
                       input logic c, input logic s, input logic u);
    @(negedge clk); #1;
    wv = v; wi = IDX_W'(i); wd = DATA_W'(d); cm = c; sq = s; su = u;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(0, 0, 0, 0, 0, 0);
  endtask

  int writes_seen = 0;
  always @(negedge clk) if (rst_n && wr_en) writes_seen++;

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    check("R1 reset count", cnt, 0);
    check("R1 reset wr_en", wr_en, 0);
    check("R9 reset serialize", ser, 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R3 R4 R10: three appends then commit
    drive(1, 5, 32'h1111, 0, 0, 0);
    drive(1, 7, 32'h2222, 0, 0, 0);
    drive(1, 9, 32'h3333, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    check("R1 count after appends", cnt, 3);
    check("R1 no write while collecting", wr_en, 0);
    w0 = writes_seen;
    drive(0, 0, 0, 1, 0, 0);
    idle(5);
    check("R3 three writes drained", writes_seen - w0, 3);
    check("R10 empty after drain", cnt, 0);

    // R5 squash
    drive(1, 1, 32'hA, 0, 0, 0);
    drive(1, 3, 32'hB, 0, 0, 0);
    w0 = writes_seen;
    drive(0, 0, 0, 0, 1, 0);
    idle(3);
    check("R5 squash empties", cnt, 0);
    check("R5 squash no writes", writes_seen - w0, 0);

    // R2 setup
    drive(1, STAT, 32'hC, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    check("R9 serialize set", ser, 1);
    drive(0, 0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0);
    check("R2 setup empties", cnt, 0);
    check("R2 setup clears serialize", ser, 0);

    // R6 overflow
    for (int k = 0; k < 5; k++) drive(1, 10 + k, 32'h100 + k, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    check("R6 count capped", cnt, DEPTH);
    w0 = writes_seen;
    drive(0, 0, 0, 1, 0, 0);
    idle(6);
    check("R6 dropped entry not written", writes_seen - w0, DEPTH);

    // R7 append with commit
    drive(1, 20, 32'hD0, 0, 0, 0);
    w0 = writes_seen;
    drive(1, 21, 32'hD1, 1, 0, 0);
    idle(4);
    check("R7 same-cycle append drained", writes_seen - w0, 2);

    // R4 empty commit
    w0 = writes_seen;
    drive(0, 0, 0, 1, 0, 0);
    idle(3);
    check("R4 empty commit no write", writes_seen - w0, 0);

    // R8 inputs ignored during drain
    drive(1, 30, 32'hE0, 0, 0, 0);
    drive(1, 31, 32'hE1, 0, 0, 0);
    drive(1, 32, 32'hE2, 0, 0, 0);
    w0 = writes_seen;
    drive(0, 0, 0, 1, 0, 0);
    drive(1, 40, 32'hF0, 0, 1, 0);
    drive(1, 41, 32'hF1, 1, 0, 1);
    idle(4);
    check("R8 drain unaffected", writes_seen - w0, 3);
    check("R8 nothing left", cnt, 0);

    // R9 serialize cleared by drain
    drive(1, STAT, 32'h5A5A, 0, 0, 0);
    drive(1, 4, 32'h6B6B, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    check("R9 serialize held in drain", ser, 1);
    idle(3);
    check("R9 serialize cleared", ser, 0);

    // R5 squash wins over commit
    drive(1, 6, 32'h77, 0, 0, 0);
    w0 = writes_seen;
    drive(0, 0, 0, 1, 1, 0);
    idle(3);
    check("R5 squash beats commit", writes_seen - w0, 0);
    check("R5 squash beats commit count", cnt, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule